// File: doc/BRIEF.md
# Bus Target Termination Classifier

This block sits beside the initiator of a parallel, PCI-style shared bus and watches the active-low FRAME, IRDY, TRDY, DEVSEL and STOP lines of one transaction at a time, one clock at a time. It does not drive any of them. When it sees how the transaction ended, it reports the result for exactly one clock as a 3-bit code. The result is one of five target-initiated endings, or a master abort when no target claimed the cycle in time. The initiator's sequencer uses the code to decide what to do next: finish, repeat the whole transaction, resume from the next word, or give up.

A transaction begins on the first clock where FRAME is asserted right after a clock in which both FRAME and IRDY were de-asserted. That first clock is the address clock. Classification starts on the clock after it. The block keeps three pieces of state for the transaction: how many data phases have completed, whether DEVSEL has been seen, and how many clocks have passed. It uses them to tell a retry apart from a disconnect that moved no data on the last phase, to catch a target abort that was never preceded by DEVSEL, and to time out an unclaimed cycle.

Top module: `bus_term_classifier`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, `outcome` is 0 (none) and `proto_err` is 0.
- R2: A clock with TRDY, DEVSEL and IRDY asserted, FRAME de-asserted and STOP de-asserted gives `outcome` = 1 (normal completion) on the following clock.
- R3: A clock with STOP and DEVSEL asserted and TRDY de-asserted, when no data phase has completed yet in the transaction, gives `outcome` = 2 (retry, transaction must be repeated).
- R4: A clock with STOP, DEVSEL and TRDY all asserted gives `outcome` = 3 (disconnect with data).
- R5: A clock with STOP and DEVSEL asserted and TRDY de-asserted, after at least one data phase has completed, gives `outcome` = 4 (disconnect without data). A data phase completes on any clock after the address clock where IRDY and TRDY are both asserted.
- R6: A clock with STOP asserted and DEVSEL de-asserted gives `outcome` = 5 (target abort). `proto_err` is 1 on that same output clock exactly when DEVSEL was not asserted on any earlier clock of the transaction after the address clock. `proto_err` is 0 on every other clock.
- R7: If DEVSEL is not asserted on any of the clocks 1 to `MA_LIMIT` (default 5) after the address clock, `outcome` = 6 (master abort) appears on the clock after clock `MA_LIMIT`. DEVSEL arriving on clock `MA_LIMIT` itself avoids the master abort.
- R8: Each transaction produces at most one non-zero code. It is held for exactly one clock, and bus activity after it is ignored until the next transaction starts. Codes 0 to 6 are the only values.
- R9: A transaction starts when FRAME is asserted after a clock with FRAME and IRDY both de-asserted. That address clock clears the state, and its TRDY, DEVSEL and STOP values are ignored.
- R10: STOP takes priority: STOP, DEVSEL and TRDY asserted with FRAME de-asserted and IRDY asserted gives 3, not 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | FRAME, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Device select, active low |
| stop_n | input | 1 | Target stop request, active low |
| outcome | output | 3 | Termination code, valid for one clock (0 none, 1 normal, 2 retry, 3 disconnect with data, 4 disconnect without data, 5 target abort, 6 master abort) |
| proto_err | output | 1 | Target abort with no earlier DEVSEL in the transaction |

## Verification
The hardest situations to create are those that depend on history rather than on the current clock. One is the target abort arriving with no DEVSEL ever seen. Another is a STOP without TRDY that follows earlier completed data phases, where the same clock pattern must give a different code. The random stimulus has a mode that withholds DEVSEL for the whole transaction, so that unclaimed aborts and master-abort timeouts occur often. The other modes mix data phases and STOP at random, so that disconnects land both before and after data has moved. Directed sequences also cover DEVSEL arriving exactly on the last allowed clock and termination patterns placed on the address clock.

// File: rtl/bus_term_classifier.sv
module bus_term_classifier #(
  parameter int MA_LIMIT = 5,
  parameter int PH_W     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic       irdy_n,
  input  logic       trdy_n,
  input  logic       devsel_n,
  input  logic       stop_n,
  output logic [2:0] outcome,
  output logic       proto_err
);
  localparam int CNT_W = $clog2(MA_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(MA_LIMIT);
  localparam logic [PH_W-1:0]  PH_MAX  = '1;

  localparam logic [2:0] OC_NONE   = 3'd0;
  localparam logic [2:0] OC_NORMAL = 3'd1;
  localparam logic [2:0] OC_RETRY  = 3'd2;
  localparam logic [2:0] OC_DWD    = 3'd3;
  localparam logic [2:0] OC_DND    = 3'd4;
  localparam logic [2:0] OC_TABORT = 3'd5;
  localparam logic [2:0] OC_MABORT = 3'd6;

  logic             prev_idle, active, seen;
  logic [CNT_W-1:0] clk_cnt;
  logic [PH_W-1:0]  phases;
  logic [2:0]       code;
  logic             err;

  wire frame  = ~frame_n;
  wire irdy   = ~irdy_n;
  wire trdy   = ~trdy_n;
  wire devsel = ~devsel_n;
  wire stop   = ~stop_n;

  wire start    = prev_idle & frame;
  wire classify = active & ~start;
  wire had_data = phases != '0;

  always_comb begin
    code = OC_NONE;
    err  = 1'b0;
    if (classify) begin
      if (stop && devsel)
        code = trdy ? OC_DWD : (had_data ? OC_DND : OC_RETRY);
      else if (stop) begin
        code = OC_TABORT;
        err  = ~seen;
      end else if (trdy && devsel && irdy && !frame)
        code = OC_NORMAL;
      else if (!seen && !devsel && clk_cnt == CNT_END)
        code = OC_MABORT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_idle <= 1'b1;
      active    <= 1'b0;
      seen      <= 1'b0;
      clk_cnt   <= '0;
      phases    <= '0;
      outcome   <= OC_NONE;
      proto_err <= 1'b0;
    end else begin
      prev_idle <= frame_n & irdy_n;
      outcome   <= code;
      proto_err <= err;
      if (start) begin
        active  <= 1'b1;
        seen    <= 1'b0;
        clk_cnt <= CNT_W'(1);
        phases  <= '0;
      end else if (classify) begin
        seen <= seen | devsel;
        if (clk_cnt != CNT_END) clk_cnt <= clk_cnt + 1'b1;
        if (irdy && trdy && phases != PH_MAX) phases <= phases + 1'b1;
        if (code != OC_NONE) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bus_term_checker.sv
module bus_term_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       irdy_n,
  input logic       trdy_n,
  input logic       devsel_n,
  input logic       stop_n,
  input logic [2:0] outcome,
  input logic       proto_err
);
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) outcome <= 3'd6); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) outcome != 3'd0 |=> outcome == 3'd0); // R8
  AST_ERR_ONLY_ABORT: assert property (@(posedge clk) disable iff (!rst_n) proto_err |-> outcome == 3'd5); // R6
  AST_NORMAL_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    outcome == 3'd1 |-> $past(!trdy_n && !devsel_n && !irdy_n && frame_n && stop_n)); // R2
  AST_RETRY_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    outcome == 3'd2 |-> $past(!stop_n && !devsel_n && trdy_n)); // R3
  AST_DWD_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    outcome == 3'd3 |-> $past(!stop_n && !devsel_n && !trdy_n)); // R4
  AST_DND_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    outcome == 3'd4 |-> $past(!stop_n && !devsel_n && trdy_n)); // R5
  AST_TABORT_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    outcome == 3'd5 |-> $past(!stop_n && devsel_n)); // R6
  AST_MABORT_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    outcome == 3'd6 |-> $past(devsel_n && stop_n)); // R7
endmodule

bind bus_term_classifier bus_term_checker u_chk (.*);

// File: tb/tb_bus_term_classifier.sv
module tb_bus_term_classifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, devsel_n = 1'b1, stop_n = 1'b1;
  logic [2:0] outcome;
  logic proto_err;

  int checks = 0;
  int fails  = 0;

  bit m_idle = 1'b1, m_act = 1'b0, m_seen = 1'b0;
  int m_cnt = 0, m_ph = 0;

  always #10 clk = ~clk;

  bus_term_classifier dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .devsel_n(devsel_n), .stop_n(stop_n), .outcome(outcome), .proto_err(proto_err)
  );

  function automatic string tag_of(logic [2:0] c);
    case (c)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input bit f, i, t, d, s, output logic [2:0] c, output bit e);
    bit fr = !f, ir = !i, tr = !t, dv = !d, st = !s;
    bit strt = m_idle && fr;
    bit cl = m_act && !strt;
    c = 3'd0;
    e = 1'b0;
    if (cl) begin
      if (st && dv) c = tr ? 3'd3 : (m_ph > 0 ? 3'd4 : 3'd2);
      else if (st) begin c = 3'd5; e = !m_seen; end
      else if (tr && dv && ir && !fr) c = 3'd1;
      else if (!m_seen && !dv && m_cnt == 5) c = 3'd6;
    end
    if (strt) begin
      m_act = 1'b1; m_seen = 1'b0; m_cnt = 1; m_ph = 0;
    end else if (cl) begin
      m_seen = m_seen | dv;
      if (m_cnt < 5) m_cnt++;
      if (ir && tr) m_ph++;
      if (c != 3'd0) m_act = 1'b0;
    end
    m_idle = f && i;
  endtask

  task automatic step(input bit f, i, t, d, s, input string tag = "", input int want = -1);
    logic [2:0] ec;
    bit ee;
    frame_n = f; irdy_n = i; trdy_n = t; devsel_n = d; stop_n = s;
    model(f, i, t, d, s, ec, ee);
    @(posedge clk);
    @(negedge clk);
    chk(outcome == ec, (tag != "") ? tag : tag_of(ec), outcome, ec);
    chk(proto_err == ee, "R6", proto_err, ee);
    if (want >= 0) chk(outcome == 3'(want), tag, outcome, want);
  endtask

  task automatic idle();  step(1, 1, 1, 1, 1); endtask
  task automatic addr();  step(0, 1, 1, 1, 1); endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(outcome == 3'd0, "R1", outcome, 0);
    chk(proto_err == 1'b0, "R1", proto_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(outcome == 3'd0, "R1", outcome, 0);

    idle(); addr(); step(0, 0, 1, 0, 1); step(1, 0, 0, 0, 1, "R2", 1);
    idle(); addr(); step(0, 0, 1, 0, 0, "R3", 2); step(0, 0, 1, 0, 0, "R8", 0);
    idle(); addr(); step(0, 0, 0, 0, 0, "R4", 3);
    idle(); addr(); step(0, 0, 0, 0, 1); step(0, 0, 1, 0, 0, "R5", 4);
    idle(); addr(); step(0, 0, 1, 0, 1); step(0, 0, 1, 1, 0, "R6", 5);
    idle(); addr(); step(0, 0, 1, 1, 0, "R6", 5);
    idle(); addr();
    for (int k = 1; k < 5; k++) step(0, 0, 1, 1, 1, "R7", 0);
    step(0, 0, 1, 1, 1, "R7", 6);
    idle(); addr();
    for (int k = 1; k < 5; k++) step(0, 0, 1, 1, 1, "R7", 0);
    step(0, 0, 1, 0, 1, "R7", 0);
    step(1, 0, 0, 0, 1, "R7", 1);
    idle(); step(0, 1, 0, 0, 0, "R9", 0); step(0, 0, 1, 1, 0, "R9", 5);
    idle(); addr(); step(1, 0, 0, 0, 0, "R10", 3);

    void'($urandom(32'd4242));
    for (int n = 0; n < 300; n++) begin
      int mode = $urandom % 4;
      int len = 1 + $urandom % 8;
      repeat (1 + $urandom % 2) idle();
      addr();
      for (int k = 0; k < len; k++) begin
        bit d = (mode == 0) ? 1'b1 : (($urandom % 10) < 7 ? 1'b0 : 1'b1);
        bit t = ($urandom % 10) < 4 ? 1'b0 : 1'b1;
        bit s = ($urandom % 10) < 2 ? 1'b0 : 1'b1;
        bit i = ($urandom % 10) < 8 ? 1'b0 : 1'b1;
        bit f = ($urandom % 10) < 3 ? 1'b1 : 1'b0;
        step(f, i, t, d, s);
      end
    end
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule